// File: doc/BRIEF.md
# Two-Bit Branch Direction Table

This block is a four-entry, direct-mapped branch direction predictor for an instruction fetch pipeline. The fetch stage presents a program counter and gets back, in the same cycle, a taken or not-taken guess for that address, along with the 2-bit state that produced the guess. A later pipeline stage reports each resolved branch through a separate update port: the branch address and whether it was actually taken. The addressed entry then moves to its next state on the following clock edge.

The entry state machine is not a plain saturating counter. A taken outcome in the weak not-taken state jumps straight to strong taken. A not-taken outcome in the weak taken state drops straight to strong not-taken. Each entry is selected by the word-aligned address bits just above the byte offset. The same selection is used for lookup and for update, so a branch trains the entry its own fetch will read.

Top module: `branch_dir_table`

## Requirements
- R1: A synchronous active-high reset sets all four entries to state 00. After reset, every lookup returns state 00 and a not-taken prediction.
- R2: The prediction is not taken for states 00 and 01, and taken for states 10 and 11.
- R3: The entry index is PC bits [3:2] for both lookup and update. All other PC bits are ignored. The lookup result follows the lookup PC in the same cycle, with no clock edge needed.
- R4: From state 00, a taken update moves the entry to 01. A not-taken update leaves it at 00.
- R5: From state 01, a taken update moves the entry to 11. A not-taken update moves it to 00.
- R6: From state 10, a taken update moves the entry to 11. A not-taken update moves it to 00.
- R7: From state 11, a taken update leaves the entry at 11. A not-taken update moves it to 10.
- R8: While the update-valid input is low, no entry changes, whatever the update PC and outcome inputs carry.
- R9: An update changes only the entry selected by its PC. The other three entries keep their states.
- R10: When a lookup and an update select the same entry in one cycle, the lookup returns the state held before the update. The new state is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_pc | input | PC_W | Fetch-stage program counter to predict for |
| predict_taken | output | 1 | 1 when the selected entry predicts taken |
| lookup_state | output | 2 | Current 2-bit state of the selected entry |
| upd_valid | input | 1 | Apply an update on this clock edge |
| upd_pc | input | PC_W | Program counter of the resolved branch |
| upd_taken | input | 1 | Resolved outcome: 1 means taken |

## Verification
A wrong transition stays hidden until the affected entry is looked up. When it is looked up, a corrupted entry shows the wrong value on `lookup_state` in the very next cycle. It changes `predict_taken` only when the error crosses the boundary between state 01 and state 10. For this reason the bench reads the 2-bit state and not only the prediction bit, after every single update. An update written to the wrong entry shows up as a change in an entry that should have stayed the same. So after updates, the bench also reads back the entries the update did not target.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

    typedef enum logic [1:0] {
        DIR_STRONG_NT = 2'b00,
        DIR_WEAK_NT   = 2'b01,
        DIR_WEAK_T    = 2'b10,
        DIR_STRONG_T  = 2'b11
    } dir_state_e;

    // Resolved branch report from the back end of the pipe
    typedef struct packed {
        logic valid;
        logic taken;
    } upd_cmd_t;

    // Next-state rule; note the jumps out of the two weak states
    function automatic dir_state_e dir_next(input dir_state_e cur, input logic taken);
        dir_state_e nxt;
        unique case (cur)
            DIR_STRONG_NT: nxt = taken ? DIR_WEAK_NT  : DIR_STRONG_NT;
            DIR_WEAK_NT:   nxt = taken ? DIR_STRONG_T : DIR_STRONG_NT;
            DIR_WEAK_T:    nxt = taken ? DIR_STRONG_T : DIR_STRONG_NT;
            default:       nxt = taken ? DIR_STRONG_T : DIR_WEAK_T;
        endcase
        return nxt;
    endfunction

    function automatic logic dir_predict(input dir_state_e cur);
        return (cur == DIR_WEAK_T) || (cur == DIR_STRONG_T);
    endfunction

endpackage

// File: rtl/bpt_index.sv
module bpt_index #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned IDX_LSB = 2,
    parameter int unsigned IDX_W   = 2
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    assign idx = pc[IDX_LSB +: IDX_W];

    // Bits outside the index field take no part in selection
    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:IDX_LSB+IDX_W], pc[IDX_LSB-1:0]};
endmodule

// File: rtl/bpt_slot.sv
module bpt_slot
    import bpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       taken,
    output dir_state_e state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DIR_STRONG_NT;
        end else if (wr_en) begin
            state <= dir_next(state, taken);
        end
    end
endmodule

// File: rtl/bpt_read.sv
module bpt_read
    import bpt_pkg::*;
#(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned IDX_W = 2
) (
    input  dir_state_e [SLOTS-1:0] states,
    input  logic [IDX_W-1:0]       idx,
    output dir_state_e             sel,
    output logic                   taken
);
    assign sel   = states[idx];
    assign taken = dir_predict(sel);
endmodule

// File: rtl/branch_dir_table.sv
module branch_dir_table
    import bpt_pkg::*;
#(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned SLOTS   = 4,
    parameter int unsigned IDX_LSB = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lookup_pc,
    output logic            predict_taken,
    output logic [1:0]      lookup_state,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int unsigned IDX_W = $clog2(SLOTS);

    logic [IDX_W-1:0]       look_idx;
    logic [IDX_W-1:0]       upd_idx;
    upd_cmd_t               cmd;
    dir_state_e [SLOTS-1:0] slot_q;
    dir_state_e             look_sel;

    assign cmd = '{valid: upd_valid, taken: upd_taken};

    bpt_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_look_idx (
        .pc  (lookup_pc),
        .idx (look_idx)
    );

    bpt_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_upd_idx (
        .pc  (upd_pc),
        .idx (upd_idx)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic sel_wr;
        assign sel_wr = cmd.valid && (upd_idx == IDX_W'(g));
        bpt_slot u_slot (
            .clk   (clk),
            .rst   (rst),
            .wr_en (sel_wr),
            .taken (cmd.taken),
            .state (slot_q[g])
        );
    end

    bpt_read #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_read (
        .states (slot_q),
        .idx    (look_idx),
        .sel    (look_sel),
        .taken  (predict_taken)
    );

    assign lookup_state = look_sel;
endmodule

// File: rtl/branch_dir_table_chk.sv
module branch_dir_table_chk #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned SLOTS   = 4,
    parameter int unsigned IDX_LSB = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [PC_W-1:0]    lookup_pc,
    input logic               predict_taken,
    input logic [1:0]         lookup_state,
    input logic               upd_valid,
    input logic [PC_W-1:0]    upd_pc,
    input logic               upd_taken,
    input logic [2*SLOTS-1:0] slot_q
);
    localparam int unsigned IDX_W = $clog2(SLOTS);

    logic [IDX_W-1:0] upd_idx;
    logic [IDX_W-1:0] look_idx;
    logic [IDX_W-1:0] upd_idx_q;
    logic [1:0]       tgt_now;
    logic [1:0]       tgt_after;

    assign upd_idx   = upd_pc[IDX_LSB +: IDX_W];
    assign look_idx  = lookup_pc[IDX_LSB +: IDX_W];
    assign tgt_now   = slot_q[2*upd_idx +: 2];
    assign tgt_after = slot_q[2*upd_idx_q +: 2];

    always_ff @(posedge clk) upd_idx_q <= upd_idx;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (slot_q == '0));

    // R2
    pred_map_chk: assert property (@(posedge clk) disable iff (rst)
        predict_taken == (lookup_state >= 2'b10));

    // R3
    lookup_sel_chk: assert property (@(posedge clk) disable iff (rst)
        lookup_state == slot_q[2*look_idx +: 2]);

    // R4
    from_snt_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && tgt_now == 2'b00) |=> (tgt_after == ($past(upd_taken) ? 2'b01 : 2'b00)));

    // R5
    from_wnt_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && tgt_now == 2'b01) |=> (tgt_after == ($past(upd_taken) ? 2'b11 : 2'b00)));

    // R6
    from_wt_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && tgt_now == 2'b10) |=> (tgt_after == ($past(upd_taken) ? 2'b11 : 2'b00)));

    // R7
    from_st_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && tgt_now == 2'b11) |=> (tgt_after == ($past(upd_taken) ? 2'b11 : 2'b10)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(slot_q));

    // R9
    for (genvar g = 0; g < SLOTS; g++) begin : g_iso
        other_slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(upd_valid && upd_idx == IDX_W'(g)) |=> $stable(slot_q[2*g +: 2]));
    end

    // R10
    same_slot_old_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_idx == look_idx) |-> (lookup_state == tgt_now));
endmodule

bind branch_dir_table branch_dir_table_chk #(
    .PC_W(PC_W), .SLOTS(SLOTS), .IDX_LSB(IDX_LSB)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .lookup_pc     (lookup_pc),
    .predict_taken (predict_taken),
    .lookup_state  (lookup_state),
    .upd_valid     (upd_valid),
    .upd_pc        (upd_pc),
    .upd_taken     (upd_taken),
    .slot_q        (slot_q)
);

// File: tb/branch_dir_table_bench.sv
module branch_dir_table_bench;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] lookup_pc = '0;
    logic            predict_taken;
    logic [1:0]      lookup_state;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    branch_dir_table u_branch_dir_table (
        .clk           (clk),
        .rst           (rst),
        .lookup_pc     (lookup_pc),
        .predict_taken (predict_taken),
        .lookup_state  (lookup_state),
        .upd_valid     (upd_valid),
        .upd_pc        (upd_pc),
        .upd_taken     (upd_taken)
    );

    function automatic logic [1:0] spec_next(input logic [1:0] s, input logic t);
        case (s)
            2'b00:   return t ? 2'b01 : 2'b00;
            2'b01:   return t ? 2'b11 : 2'b00;
            2'b10:   return t ? 2'b11 : 2'b00;
            default: return t ? 2'b11 : 2'b10;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Looks up pc and checks both state and prediction (prediction per R2)
    task automatic peek(input string req, input logic [PC_W-1:0] pc, input logic [1:0] exp);
        lookup_pc = pc;
        #1;
        chk(req, int'(lookup_state), int'(exp));
        chk({req, "/R2"}, int'(predict_taken), int'(exp[1]));
    endtask

    // Called at a negedge; returns at the next negedge
    task automatic upd(input logic [PC_W-1:0] pc, input logic t);
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = t;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // From reset, drive slot of pc into state s
    task automatic reach(input logic [PC_W-1:0] pc, input logic [1:0] s);
        do_reset();
        case (s)
            2'b01: upd(pc, 1'b1);
            2'b11: begin upd(pc, 1'b1); upd(pc, 1'b1); end
            2'b10: begin upd(pc, 1'b1); upd(pc, 1'b1); upd(pc, 1'b0); end
            default: ;
        endcase
    endtask

    task automatic t_reset();
        do_reset();
        for (int i = 0; i < 4; i++) peek("R1", PC_W'(i * 4), 2'b00);
    endtask

    task automatic t_preload();
        do_reset();
        upd(32'h0000_0000, 1'b1);
        upd(32'h0000_0008, 1'b1);
        upd(32'h0000_0008, 1'b1);
        upd(32'h0000_000C, 1'b1);
        peek("R3", 32'h0000_0000, 2'b01);
        peek("R3", 32'h0000_0004, 2'b00);
        peek("R3", 32'h0000_0008, 2'b11);
        peek("R3", 32'h0000_000C, 2'b01);
        // PC 0x14 selects slot 1: not taken
        peek("R3", 32'h0000_0014, 2'b00);
        peek("R3", 32'h0000_0015, 2'b00);
        peek("R3", 32'hABCD_0018, 2'b11);
    endtask

    task automatic t_walk();
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 2; t++) begin
                string tag;
                case (s)
                    0: tag = "R4";
                    1: tag = "R5";
                    2: tag = "R6";
                    default: tag = "R7";
                endcase
                reach(32'h0000_0004, 2'(s));
                peek(tag, 32'h0000_0004, 2'(s));
                // high bits differ but index field still selects slot 1
                upd(32'hFFF0_0006, 1'(t));
                peek(tag, 32'h0000_0004, spec_next(2'(s), 1'(t)));
            end
        end
    endtask

    task automatic t_idle();
        reach(32'h0000_0008, 2'b11);
        lookup_pc = 32'h0000_0008;
        for (int k = 0; k < 6; k++) begin
            upd_pc    = PC_W'(k * 4);
            upd_taken = k[0];
            @(negedge clk);
        end
        peek("R8", 32'h0000_0008, 2'b11);
        peek("R8", 32'h0000_0000, 2'b00);
    endtask

    task automatic t_isolate();
        do_reset();
        upd(32'h0000_0004, 1'b1);
        upd(32'h0000_0008, 1'b1);
        upd(32'h0000_0008, 1'b1);
        upd(32'h0000_0008, 1'b0);
        peek("R9", 32'h0000_0008, 2'b10);
        peek("R9", 32'h0000_0004, 2'b01);
        peek("R9", 32'h0000_0000, 2'b00);
        peek("R9", 32'h0000_000C, 2'b00);
    endtask

    task automatic t_same_cycle();
        reach(32'h0000_000C, 2'b01);
        lookup_pc = 32'h0000_000C;
        upd_valid = 1'b1;
        upd_pc    = 32'h0000_000C;
        upd_taken = 1'b1;
        #1;
        chk("R10", int'(lookup_state), 1);
        chk("R10", int'(predict_taken), 0);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        chk("R10", int'(lookup_state), 3);
        chk("R10", int'(predict_taken), 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #100000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_preload();
        t_walk();
        t_idle();
        t_isolate();
        t_same_cycle();
        finish_run();
    end
endmodule